// File: doc/BRIEF.md
# Macro Result Dispatch and Method Writer

This block sits beside a macro sequencer and handles the back end of every executed macro step. For each step the sequencer hands over a computed result word, a 3-bit result-mode code and a destination register index. The block decides what goes back into the macro register file and what, if anything, leaves on the method-write port as an address/data pair.

It owns two pieces of state. The first is a queue of parameter words loaded ahead of execution. The second is a method-address register that holds a 12-bit address with a 6-bit auto-increment step. At the end of a macro it flags any parameter that was never consumed. A fetch from an exhausted queue is also flagged.

A step is issued as a one-cycle strobe and must not be issued again until `step_done` has pulsed. Parameters are loaded with single-cycle push strobes, never in the same cycle as a step strobe.

Top module: `macro_dispatch`

## Requirements
- R1: After reset or a `macro_start` strobe, `prm_err` is low, the method address and step fields are zero and the parameter read index is 1, so the first send goes to address 0.
- R2: The first word pushed after `macro_start` is written to register 1 through the writeback port in the cycle after the push (`rf_we`=1, `rf_idx`=1).
- R3: Mode 0 writes the next fetched parameter to dst and discards the result. Mode 1 writes the result to dst. The writeback appears one cycle after the step strobe.
- R4: Mode 2 writes the result to dst and loads result bits [17:0] into the method register. Mode 5 writes the next fetched parameter to dst and loads the result into the method register. Address is bits [11:0] and step is bits [17:12].
- R5: Mode 3 writes the next fetched parameter to dst and sends the result. Mode 4 writes the result to dst and sends it. Both sends use the current method address.
- R6: Modes 6 and 7 write the result to dst and load it as the method register, then send at the newly loaded address. Mode 6 sends a freshly fetched parameter. Mode 7 sends result bits [17:12], zero-extended.
- R7: After each accepted send, the address field advances by the step field, modulo 4096.
- R8: A step with destination index 0 produces no writeback.
- R9: A send holds `mth_valid`, `mth_addr` and `mth_data` steady until `mth_ready`. `step_done` pulses the cycle after the handshake. A step without a send pulses `step_done` the cycle after its strobe.
- R10: Fetching when every loaded parameter has already been read sets the sticky `prm_err`, and the fetched value is 0.
- R11: A `macro_end` strobe with unread parameters sets `prm_err`. A macro that consumed exactly its parameters ends with `prm_err` low. `macro_start` clears `prm_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| macro_start | input | 1 | Strobe: begin a new macro, clear queue and state |
| macro_end | input | 1 | Strobe: macro finished, check parameter usage |
| prm_push | input | 1 | Strobe: append `prm_data` to the parameter queue |
| prm_data | input | DATA_W | Parameter word |
| step_go | input | 1 | Strobe: one step from the sequencer |
| step_mode | input | 3 | Result-mode code 0..7 |
| step_dst | input | IDX_W | Destination register index |
| step_result | input | DATA_W | Result word computed by the sequencer |
| step_done | output | 1 | Pulse: step fully handled |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | IDX_W | Register-file write index |
| rf_data | output | DATA_W | Register-file write data |
| mth_valid | output | 1 | Method write request |
| mth_ready | input | 1 | Method write accepted |
| mth_addr | output | ADDR_W | Method address |
| mth_data | output | DATA_W | Method data |
| prm_err | output | 1 | Sticky parameter usage error |

## Verification
The hardest situation to reach is a send whose target address has wrapped past 4095 while the port is stalled. Reaching it also needs an earlier mode to have loaded both a large address and a nonzero step. A directed sequence loads address 0xFFE with step 5 and sends twice, so the second send lands at 0x003. Separately, random macros draw mode codes, destinations, parameter counts and ready delays. This randomness naturally produces queue underflows, leftovers and multi-cycle stalls, all compared against a bench model of the queue and method register.

// File: rtl/macro_dispatch_pkg.sv
package macro_dispatch_pkg;

    typedef enum logic [2:0] {
        RM_FETCH_ONLY      = 3'd0,
        RM_MOVE            = 3'd1,
        RM_MOVE_SETA       = 3'd2,
        RM_FETCH_SENDR     = 3'd3,
        RM_MOVE_SENDR      = 3'd4,
        RM_FETCH_SETA      = 3'd5,
        RM_MOVE_SETA_SENDP = 3'd6,
        RM_MOVE_SETA_SENDF = 3'd7
    } res_mode_e;

    typedef enum logic [1:0] {
        SRC_RESULT = 2'd0,
        SRC_PARAM  = 2'd1,
        SRC_FIELD  = 2'd2
    } send_src_e;

    typedef struct packed {
        logic      fetch;
        logic      wb_param;
        logic      set_addr;
        logic      send;
        send_src_e src;
    } mode_ctl_t;

endpackage

// File: rtl/macro_mode_decode.sv
module macro_mode_decode
    import macro_dispatch_pkg::*;
(
    input  logic [2:0] mode,
    output mode_ctl_t  ctl
);

    always_comb begin
        ctl = '{fetch: 1'b0, wb_param: 1'b0, set_addr: 1'b0, send: 1'b0, src: SRC_RESULT};
        unique case (res_mode_e'(mode))
            RM_FETCH_ONLY:      begin ctl.fetch = 1'b1; ctl.wb_param = 1'b1; end
            RM_MOVE:            ;
            RM_MOVE_SETA:       ctl.set_addr = 1'b1;
            RM_FETCH_SENDR:     begin ctl.fetch = 1'b1; ctl.wb_param = 1'b1; ctl.send = 1'b1; end
            RM_MOVE_SENDR:      ctl.send = 1'b1;
            RM_FETCH_SETA:      begin ctl.fetch = 1'b1; ctl.wb_param = 1'b1; ctl.set_addr = 1'b1; end
            RM_MOVE_SETA_SENDP: begin ctl.fetch = 1'b1; ctl.set_addr = 1'b1; ctl.send = 1'b1;
                                      ctl.src = SRC_PARAM; end
            RM_MOVE_SETA_SENDF: begin ctl.set_addr = 1'b1; ctl.send = 1'b1; ctl.src = SRC_FIELD; end
            default:            ;
        endcase
    end

endmodule

// File: rtl/macro_prm_queue.sv
module macro_prm_queue #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              leftover,
    output logic              first
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rd;
    } qst_t;

    qst_t q_q, q_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign empty    = q_q.rd >= q_q.cnt;
    assign full     = q_q.cnt == CW'(DEPTH);
    assign leftover = q_q.rd < q_q.cnt;
    assign first    = q_q.cnt == '0;
    assign head     = (q_q.rd < CW'(DEPTH)) ? mem_q[q_q.rd[IW-1:0]] : '0;

    always_comb begin
        q_d = q_q;
        if (clr) begin
            q_d.cnt = '0;
            q_d.rd  = CW'(1);
        end else begin
            if (push && !full) q_d.cnt = q_q.cnt + CW'(1);
            if (pop && !empty) q_d.rd  = q_q.rd + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.cnt <= '0;
            q_q.rd  <= CW'(1);
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clr) mem_q[q_q.cnt[IW-1:0]] <= push_data;
    end

    AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.rd <= q_q.cnt) || (q_q.rd == CW'(1))); // R10

endmodule

// File: rtl/macro_dispatch.sv
module macro_dispatch
    import macro_dispatch_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int STEP_W    = 6,
    parameter int NREG      = 8,
    parameter int PRM_DEPTH = 16,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              macro_start,
    input  logic              macro_end,
    input  logic              prm_push,
    input  logic [DATA_W-1:0] prm_data,
    input  logic              step_go,
    input  logic [2:0]        step_mode,
    input  logic [IDX_W-1:0]  step_dst,
    input  logic [DATA_W-1:0] step_result,
    output logic              step_done,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_data,
    output logic              mth_valid,
    input  logic              mth_ready,
    output logic [ADDR_W-1:0] mth_addr,
    output logic [DATA_W-1:0] mth_data,
    output logic              prm_err
);

    localparam int MW = ADDR_W + STEP_W;

    typedef struct packed {
        logic [MW-1:0]     maddr;
        logic              mvalid;
        logic [ADDR_W-1:0] maddr_out;
        logic [DATA_W-1:0] mdata;
        logic              rf_we;
        logic [IDX_W-1:0]  rf_idx;
        logic [DATA_W-1:0] rf_data;
        logic              done;
        logic              err;
    } st_t;

    st_t s_q, s_d;
    mode_ctl_t ctl;

    logic [DATA_W-1:0] q_head;
    logic q_empty, q_full, q_left, q_first, q_pop;
    logic accept;
    logic [DATA_W-1:0] fetch_val, wb_val, send_val;
    logic [MW-1:0] new_ma;

    macro_mode_decode i_dec (
        .mode (step_mode),
        .ctl  (ctl)
    );

    macro_prm_queue #(.DATA_W(DATA_W), .DEPTH(PRM_DEPTH)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (macro_start),
        .push      (prm_push),
        .push_data (prm_data),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .leftover  (q_left),
        .first     (q_first)
    );

    assign accept    = step_go && !s_q.mvalid && !macro_start;
    assign q_pop     = accept && ctl.fetch;
    assign fetch_val = q_empty ? '0 : q_head;
    assign wb_val    = ctl.wb_param ? fetch_val : step_result;
    assign new_ma    = ctl.set_addr ? step_result[MW-1:0] : s_q.maddr;

    always_comb begin
        unique case (ctl.src)
            SRC_PARAM: send_val = fetch_val;
            SRC_FIELD: send_val = DATA_W'(step_result[MW-1:ADDR_W]);
            default:   send_val = step_result;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.rf_we = 1'b0;
        s_d.done  = 1'b0;
        if (macro_start) begin
            s_d.maddr  = '0;
            s_d.mvalid = 1'b0;
            s_d.err    = 1'b0;
        end else begin
            if (prm_push && q_first) begin
                s_d.rf_we   = 1'b1;
                s_d.rf_idx  = IDX_W'(1);
                s_d.rf_data = prm_data;
            end
            if (prm_push && q_full) s_d.err = 1'b1;
            if (macro_end && q_left) s_d.err = 1'b1;
            if (accept) begin
                if (ctl.fetch && q_empty) s_d.err = 1'b1;
                if (step_dst != '0) begin
                    s_d.rf_we   = 1'b1;
                    s_d.rf_idx  = step_dst;
                    s_d.rf_data = wb_val;
                end
                s_d.maddr = new_ma;
                if (ctl.send) begin
                    s_d.mvalid    = 1'b1;
                    s_d.maddr_out = new_ma[ADDR_W-1:0];
                    s_d.mdata     = send_val;
                end else begin
                    s_d.done = 1'b1;
                end
            end
            if (s_q.mvalid && mth_ready) begin
                s_d.mvalid = 1'b0;
                s_d.done   = 1'b1;
                s_d.maddr[ADDR_W-1:0] = s_q.maddr[ADDR_W-1:0] + ADDR_W'(s_q.maddr[MW-1:ADDR_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign step_done = s_q.done;
    assign rf_we     = s_q.rf_we;
    assign rf_idx    = s_q.rf_idx;
    assign rf_data   = s_q.rf_data;
    assign mth_valid = s_q.mvalid;
    assign mth_addr  = s_q.maddr_out;
    assign mth_data  = s_q.mdata;
    assign prm_err   = s_q.err;

    AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_go |-> !mth_valid); // R9
    AST_NO_PUSH_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(prm_push && step_go)); // R2
    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mth_valid && !mth_ready && !macro_start |=>
        mth_valid && $stable(mth_addr) && $stable(mth_data)); // R9
    AST_DONE_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        mth_valid && mth_ready && !macro_start |=> step_done && !mth_valid); // R9
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mth_valid && mth_ready && !macro_start |=>
        s_q.maddr[ADDR_W-1:0] == $past(mth_addr + ADDR_W'(s_q.maddr[MW-1:ADDR_W]))); // R7
    AST_NO_ZERO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_idx != '0); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prm_err && !macro_start |=> prm_err); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        macro_start |=> !prm_err && !mth_valid); // R11

endmodule

// File: tb/test_macro_dispatch.sv
module test_macro_dispatch;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic macro_start = 0, macro_end = 0, prm_push = 0, step_go = 0, mth_ready = 0;
    logic [31:0] prm_data = '0, step_result = '0;
    logic [2:0] step_mode = '0, step_dst = '0;
    logic step_done, rf_we, mth_valid, prm_err;
    logic [2:0] rf_idx;
    logic [31:0] rf_data, mth_data;
    logic [11:0] mth_addr;

    always #5 clk = ~clk;

    macro_dispatch i_macro_dispatch (
        .clk(clk), .rst_n(rst_n), .macro_start(macro_start), .macro_end(macro_end),
        .prm_push(prm_push), .prm_data(prm_data), .step_go(step_go), .step_mode(step_mode),
        .step_dst(step_dst), .step_result(step_result), .step_done(step_done),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .mth_valid(mth_valid),
        .mth_ready(mth_ready), .mth_addr(mth_addr), .mth_data(mth_data), .prm_err(prm_err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [11:0] m_ma;
    logic [5:0]  m_st;
    logic [31:0] m_q [16];
    int m_cnt, m_rd;
    bit m_err;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {fetch, write-param, set-address, send, source[1:0]}: 0 result, 1 parameter, 2 field
    function automatic logic [5:0] mode_info(input int m);
        case (m)
            0: return 6'b110000;
            1: return 6'b000000;
            2: return 6'b001000;
            3: return 6'b110100;
            4: return 6'b000100;
            5: return 6'b111000;
            6: return 6'b101101;
            default: return 6'b001110;
        endcase
    endfunction

    function automatic string mode_req(input int m);
        case (m)
            0, 1: return "R3";
            2, 5: return "R4";
            3, 4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic do_start();
        macro_start = 1;
        @(negedge clk);
        macro_start = 0;
        m_cnt = 0; m_rd = 1; m_err = 0; m_ma = '0; m_st = '0;
        chk(!prm_err && !mth_valid, "R11 start clears error", {31'b0, prm_err}, 32'd0);
    endtask

    task automatic do_push(input logic [31:0] d);
        prm_push = 1; prm_data = d;
        @(negedge clk);
        prm_push = 0;
        if (m_cnt == 0)
            chk(rf_we && rf_idx == 3'd1 && rf_data == d, "R2 first parameter to register 1", rf_data, d);
        m_q[m_cnt] = d;
        m_cnt++;
    endtask

    task automatic do_end();
        macro_end = 1;
        @(negedge clk);
        macro_end = 0;
        if (m_rd < m_cnt) m_err = 1;
        chk(prm_err == m_err, "R11 end-of-macro check", {31'b0, prm_err}, {31'b0, m_err});
    endtask

    task automatic do_step(input int mode, input logic [2:0] dst, input logic [31:0] res);
        logic [5:0] inf;
        logic [31:0] fv, wbv, sd;
        string rq;
        int k;
        inf = mode_info(mode);
        rq = mode_req(mode);
        fv = '0;
        if (inf[5]) begin
            if (m_rd < m_cnt) begin fv = m_q[m_rd]; m_rd++; end
            else m_err = 1;
        end
        wbv = inf[4] ? fv : res;
        if (inf[3]) begin m_ma = res[11:0]; m_st = res[17:12]; end
        sd = (inf[1:0] == 2'd1) ? fv : (inf[1:0] == 2'd2) ? {26'b0, res[17:12]} : res;
        step_go = 1; step_mode = 3'(mode); step_dst = dst; step_result = res;
        @(negedge clk);
        step_go = 0;
        if (dst != 0)
            chk(rf_we && rf_idx == dst && rf_data == wbv, {rq, " writeback"}, rf_data, wbv);
        else
            chk(!rf_we, "R8 destination 0 suppressed", {31'b0, rf_we}, 32'd0);
        chk(prm_err == m_err, "R10 underflow error", {31'b0, prm_err}, {31'b0, m_err});
        if (inf[2]) begin
            chk(mth_valid && mth_addr == m_ma, {rq, " / R7 send address"}, {20'b0, mth_addr}, {20'b0, m_ma});
            chk(mth_data == sd, {rq, " send data"}, mth_data, sd);
            chk(!step_done, "R9 done waits for port", {31'b0, step_done}, 32'd0);
            k = int'($urandom % 4);
            for (int i = 0; i < k; i++) begin
                @(negedge clk);
                chk(mth_valid && mth_addr == m_ma && mth_data == sd && !step_done,
                    "R9 held during stall", mth_data, sd);
            end
            mth_ready = 1;
            @(negedge clk);
            mth_ready = 0;
            chk(step_done && !mth_valid, "R9 done after handshake", {31'b0, step_done}, 32'd1);
            m_ma = m_ma + 12'(m_st);
        end else begin
            chk(step_done && !mth_valid, "R9 done after plain step", {31'b0, step_done}, 32'd1);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned junk;
        junk = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!prm_err && !mth_valid && !step_done && !rf_we, "R1 reset state", {31'b0, prm_err}, 32'd0);

        // directed: send at zero address, wrap, modes 2/3/6/7, destination 0, underflow
        do_start();
        do_push(32'hA000_0001);
        do_push(32'hB000_0002);
        do_push(32'hC000_0003);
        do_step(4, 3'd1, 32'h1234_5678);                  // R1: address 0
        do_step(2, 3'd2, {14'h0, 6'd5, 12'hFFE});         // R4
        do_step(4, 3'd3, 32'h0000_0044);                  // at 0xFFE
        do_step(3, 3'd2, 32'h0000_0055);                  // R7: wraps to 0x003
        do_step(7, 3'd0, {14'h0, 6'd9, 12'h100});         // R6 field, R8
        do_step(6, 3'd3, {14'h0, 6'd1, 12'h200});         // R6 parameter
        do_step(0, 3'd4, 32'h0);                          // R10 underflow
        do_end();

        // directed: clean macro with mode 5
        do_start();
        do_push(32'h1111_1111);
        do_push(32'h2222_2222);
        do_push(32'h3333_3333);
        do_step(0, 3'd5, 32'hDEAD_BEEF);
        do_step(5, 3'd6, {14'h0, 6'd2, 12'h0F0});
        do_step(4, 3'd7, 32'h0000_0077);
        do_step(1, 3'd1, 32'h0BAD_F00D);
        do_end();

        // directed: leftover parameter
        do_start();
        do_push(32'h5);
        do_push(32'h6);
        do_step(1, 3'd6, 32'h7);
        do_end();

        // random macros
        for (int mac = 0; mac < 40; mac++) begin
            int np, ns;
            do_start();
            np = 1 + int'($urandom % 6);
            for (int p = 0; p < np; p++) do_push($urandom);
            ns = 1 + int'($urandom % 8);
            for (int s = 0; s < ns; s++)
                do_step(int'($urandom % 8), 3'($urandom), $urandom);
            do_end();
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule